// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a hardware master for a small three-wire serial EEPROM. It reads one 16-bit word per request. It drives the chip select, serial clock and data-in lines, and it samples the data-out line. Each read sends a fixed 10-bit command frame and then clocks in 16 data bits, most significant bit first. Every phase of the serial waveform has a minimum length in nanoseconds. The block converts each of these to system clock cycles from a clock-frequency parameter and rounds the result up. A phase never lasts less than one cycle.

A request arrives on a valid/ready handshake. It carries a 4-bit word address and a mode bit. In single mode the block returns the addressed word. In station mode the block reads words 0, 1 and 2 back to back and packs them into a 48-bit station address. Within each word, the upper byte becomes the earlier address byte.

The result side has no back-pressure. `done` pulses for one cycle, and the result registers hold their values until the next pulse. A caller stalls the block only by holding `req_valid` low.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is held and right after it is released, `ee_cs`, `ee_sk`, `ee_di` and `done` are low, `req_ready` is high, and `rd_word` and `station_addr` are zero.
- R2: Each read shifts out a 10-bit frame MSB first, equal to 0x180 OR the word address. Bit 9 is 0, bits 8 and 7 are 1, bits 6 to 4 are 0, and bits 3 to 0 hold the address. `ee_di` is low during all 16 data clocks.
- R3: `ee_cs` is high for at least CSS+DIS cycles before the first rising edge of `ee_sk`. `ee_di` is stable for at least DIS cycles before every rising edge. `ee_sk` is high only while `ee_cs` is high.
- R4: Every high phase of `ee_sk` lasts at least SKH cycles, and every low phase between two bits of a frame lasts at least SKL cycles.
- R5: A frame has exactly 26 clock pulses. The last 16 return the data word MSB first, each bit sampled at the end of its high phase. In single mode, `rd_word` equals the stored word.
- R6: After the last data bit, `ee_cs` goes low and stays low for at least CSH cycles before the next frame starts. `done` is never high while `ee_cs` is high.
- R7: Station mode ignores `req_addr`. It reads addresses 0, 1 and 2 in that order and sets `station_addr` = {word0, word1, word2}, so word0[15:8] is the first byte at bits 47:40. `rd_word` then holds word2.
- R8: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from acceptance until the cycle after `done`. A `req_valid` raised while `req_ready` is low has no effect on the frame, the result or the number of `done` pulses.
- R9: `done` is a single-cycle pulse. `rd_word` and `station_addr` change only in the cycle `done` is high. A single-mode read leaves `station_addr` unchanged.
- R10: Let E = CSS + 26*(DIS+SKH+SKL) + CSH, with each term being ceil(ns*CLK_MHZ/1000) and at least 1. Then `done` is high in the cycle after clock edge E+1, counted from the accepting edge, for a single read, and after edge 3*(E+1) for a station read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_station | input | 1 | 1 = read words 0..2 and pack them; 0 = read one word |
| req_addr | input | ADDR_W | Word address for single mode |
| done | output | 1 | One-cycle completion strobe |
| rd_word | output | DATA_W | Last word read |
| station_addr | output | STATION_WORDS*DATA_W | Packed station address |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench computes the exact completion time from the rounded phase counts. For a single read, `done` is due at edge E+1 after the accepting edge. For a station read it is due at edge 3*(E+1), because each word adds one cycle for the engine's completion strobe. The bench counts rising edges from acceptance and samples `done` at each falling edge, so each check lands on the predicted cycle and not on a window. A serial EEPROM model samples the pins at falling edges and measures every phase length in cycles against the rounded minimums. The bench compares results with the model array in the cycle of the pulse, and again one cycle later to confirm that the pulse lasts one cycle.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  localparam int unsigned FRAME_W = 10;
  localparam logic [FRAME_W-1:0] READ_HDR = 10'h180;

  typedef enum logic [2:0] {
    E_IDLE,
    E_CSS,
    E_SETUP,
    E_HIGH,
    E_LOW,
    E_CSH
  } eng_state_t;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mwr_phase_timer.sv
module mwr_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/mwr_word_engine.sv
module mwr_word_engine
  import mwr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CSS_CYC = 4,
  parameter int unsigned DIS_CYC = 2,
  parameter int unsigned SKH_CYC = 4,
  parameter int unsigned SKL_CYC = 4,
  parameter int unsigned CSH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              word_done,
  output logic [DATA_W-1:0] word_out,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int unsigned TOTAL_BITS = FRAME_W + DATA_W;
  localparam int unsigned IDX_W      = $clog2(TOTAL_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(TOTAL_BITS - 1);
  localparam logic [IDX_W-1:0] FIRST_DAT = IDX_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CSS_LD = CNT_W'(CSS_CYC - 1);
  localparam logic [CNT_W-1:0] DIS_LD = CNT_W'(DIS_CYC - 1);
  localparam logic [CNT_W-1:0] SKH_LD = CNT_W'(SKH_CYC - 1);
  localparam logic [CNT_W-1:0] SKL_LD = CNT_W'(SKL_CYC - 1);
  localparam logic [CNT_W-1:0] CSH_LD = CNT_W'(CSH_CYC - 1);

  eng_state_t        state_q;
  logic [IDX_W-1:0]  bit_idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0] shift_q;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              t_exp;

  mwr_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  // Each transition loads the length of the phase being entered.
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state_q)
      E_IDLE:  if (start) begin t_load = 1'b1; t_val = CSS_LD; end
      E_CSS:   if (t_exp) begin t_load = 1'b1; t_val = DIS_LD; end
      E_SETUP: if (t_exp) begin t_load = 1'b1; t_val = SKH_LD; end
      E_HIGH:  if (t_exp) begin t_load = 1'b1; t_val = SKL_LD; end
      E_LOW:   if (t_exp) begin
                 t_load = 1'b1;
                 t_val  = (bit_idx_q == LAST_IDX) ? CSH_LD : DIS_LD;
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= E_IDLE;
      bit_idx_q <= '0;
      frame_q   <= '0;
      shift_q   <= '0;
      word_out  <= '0;
      word_done <= 1'b0;
      ee_cs     <= 1'b0;
      ee_sk     <= 1'b0;
      ee_di     <= 1'b0;
    end else begin
      word_done <= 1'b0;
      unique case (state_q)
        E_IDLE: begin
          if (start) begin
            state_q   <= E_CSS;
            ee_cs     <= 1'b1;
            ee_di     <= 1'b0;
            bit_idx_q <= '0;
            frame_q   <= READ_HDR | FRAME_W'(addr);
          end
        end
        E_CSS: begin
          if (t_exp) begin
            state_q <= E_SETUP;
            ee_di   <= frame_q[FRAME_W-1];
          end
        end
        E_SETUP: begin
          if (t_exp) begin
            state_q <= E_HIGH;
            ee_sk   <= 1'b1;
          end
        end
        E_HIGH: begin
          if (t_exp) begin
            state_q <= E_LOW;
            ee_sk   <= 1'b0;
            if (bit_idx_q >= FIRST_DAT) shift_q <= {shift_q[DATA_W-2:0], ee_do};
          end
        end
        E_LOW: begin
          if (t_exp) begin
            if (bit_idx_q == LAST_IDX) begin
              state_q <= E_CSH;
              ee_cs   <= 1'b0;
              ee_di   <= 1'b0;
            end else begin
              state_q   <= E_SETUP;
              bit_idx_q <= bit_idx_q + 1'b1;
              frame_q   <= {frame_q[FRAME_W-2:0], 1'b0};
              ee_di     <= frame_q[FRAME_W-2];
            end
          end
        end
        E_CSH: begin
          if (t_exp) begin
            state_q   <= E_IDLE;
            word_done <= 1'b1;
            word_out  <= shift_q;
          end
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end

  assign busy = (state_q != E_IDLE);

endmodule

// File: rtl/mwr_station_seq.sv
module mwr_station_seq #(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned STATION_WORDS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_fire,
  input  logic                            req_station,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic                            eng_done,
  input  logic [DATA_W-1:0]               eng_word,
  output logic                            eng_start,
  output logic [ADDR_W-1:0]               eng_addr,
  output logic                            active,
  output logic                            done,
  output logic [DATA_W-1:0]               rd_word,
  output logic [STATION_WORDS*DATA_W-1:0] station_addr
);

  localparam int unsigned STATION_W = STATION_WORDS * DATA_W;
  localparam int unsigned IDX_W     = (STATION_WORDS > 1) ? $clog2(STATION_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STATION_WORDS - 1);

  logic                 station_q;
  logic [IDX_W-1:0]     widx_q;
  logic [STATION_W-1:0] pack_q;
  logic [STATION_W-1:0] pack_nx;
  logic                 more_words;

  // Earlier words land in the more significant slots.
  always_comb begin
    pack_nx = pack_q;
    pack_nx[(STATION_WORDS - 1 - int'(widx_q)) * DATA_W +: DATA_W] = eng_word;
  end

  assign more_words = active && station_q && eng_done && (widx_q != LAST_IDX);
  assign eng_start  = req_fire || more_words;
  assign eng_addr   = req_fire ? (req_station ? '0 : req_addr) : ADDR_W'(widx_q + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      station_q    <= 1'b0;
      widx_q       <= '0;
      pack_q       <= '0;
      done         <= 1'b0;
      rd_word      <= '0;
      station_addr <= '0;
    end else begin
      done <= 1'b0;
      if (req_fire) begin
        active    <= 1'b1;
        station_q <= req_station;
        widx_q    <= '0;
      end else if (active && eng_done) begin
        if (station_q) begin
          pack_q <= pack_nx;
          if (widx_q == LAST_IDX) begin
            active       <= 1'b0;
            done         <= 1'b1;
            rd_word      <= eng_word;
            station_addr <= pack_nx;
          end else begin
            widx_q <= widx_q + 1'b1;
          end
        end else begin
          active  <= 1'b0;
          done    <= 1'b1;
          rd_word <= eng_word;
        end
      end
    end
  end

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mwr_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 250,
  parameter int unsigned T_CSS_NS      = 1000,
  parameter int unsigned T_DIS_NS      = 400,
  parameter int unsigned T_SKH_NS      = 2000,
  parameter int unsigned T_SKL_NS      = 2000,
  parameter int unsigned T_CSH_NS      = 1000,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned STATION_WORDS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_station,
  input  logic [ADDR_W-1:0]               req_addr,
  output logic                            done,
  output logic [DATA_W-1:0]               rd_word,
  output logic [STATION_WORDS*DATA_W-1:0] station_addr,
  output logic                            ee_cs,
  output logic                            ee_sk,
  output logic                            ee_di,
  input  logic                            ee_do
);

  localparam int unsigned CSS_CYC = ns2cyc(T_CSS_NS, CLK_MHZ);
  localparam int unsigned DIS_CYC = ns2cyc(T_DIS_NS, CLK_MHZ);
  localparam int unsigned SKH_CYC = ns2cyc(T_SKH_NS, CLK_MHZ);
  localparam int unsigned SKL_CYC = ns2cyc(T_SKL_NS, CLK_MHZ);
  localparam int unsigned CSH_CYC = ns2cyc(T_CSH_NS, CLK_MHZ);
  localparam int unsigned MAX_CYC =
    max2(max2(max2(CSS_CYC, DIS_CYC), max2(SKH_CYC, SKL_CYC)), CSH_CYC);
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic              eng_start;
  logic [ADDR_W-1:0] eng_addr;
  logic              eng_busy;
  logic              eng_done;
  logic [DATA_W-1:0] eng_word;
  logic              seq_active;
  logic              req_fire;

  assign req_ready = !seq_active && !eng_busy;
  assign req_fire  = req_valid && req_ready;

  mwr_station_seq #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .STATION_WORDS (STATION_WORDS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_fire     (req_fire),
    .req_station  (req_station),
    .req_addr     (req_addr),
    .eng_done     (eng_done),
    .eng_word     (eng_word),
    .eng_start    (eng_start),
    .eng_addr     (eng_addr),
    .active       (seq_active),
    .done         (done),
    .rd_word      (rd_word),
    .station_addr (station_addr)
  );

  mwr_word_engine #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .CSS_CYC (CSS_CYC),
    .DIS_CYC (DIS_CYC),
    .SKH_CYC (SKH_CYC),
    .SKL_CYC (SKL_CYC),
    .CSH_CYC (CSH_CYC)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .addr      (eng_addr),
    .busy      (eng_busy),
    .word_done (eng_done),
    .word_out  (eng_word),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di),
    .ee_do     (ee_do)
  );

endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STATION_W = 48,
  parameter int unsigned CSH_CYC   = 4,
  parameter int unsigned GAP_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 done,
  input logic [DATA_W-1:0]    rd_word,
  input logic [STATION_W-1:0] station_addr,
  input logic                 ee_cs,
  input logic                 ee_sk,
  input logic                 ee_di
);

  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(CSH_CYC);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= GAP_MAX;
    else if (ee_cs) gap_q <= '0;
    else if (gap_q < GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  // R3
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs);
  // R3
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> $stable(ee_di));
  // R4
  sk_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_sk) |=> ee_sk);
  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> (gap_q >= GAP_MAX));
  // R6
  done_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ee_cs);
  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) ee_cs |-> !req_ready);
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(rd_word));
  // R9
  station_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(station_addr));

endmodule

bind mw_eeprom_reader mwr_checker #(
  .DATA_W    (DATA_W),
  .STATION_W (STATION_WORDS * DATA_W),
  .CSH_CYC   (CSH_CYC),
  .GAP_W     (CNT_W + 1)
) u_mwr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .done         (done),
  .rd_word      (rd_word),
  .station_addr (station_addr),
  .ee_cs        (ee_cs),
  .ee_sk        (ee_sk),
  .ee_di        (ee_di)
);

// File: tb/tb_mw_eeprom_reader.sv
module tb_mw_eeprom_reader;

  localparam int unsigned MHZ = 250;
  localparam int unsigned CSS_NS = 16, DIS_NS = 8, SKH_NS = 12, SKL_NS = 10, CSH_NS = 20;

  function automatic int unsigned cyc(input int unsigned ns);
    int unsigned c;
    c = (ns * MHZ + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  localparam int unsigned CSS = cyc(CSS_NS);
  localparam int unsigned DIS = cyc(DIS_NS);
  localparam int unsigned SKH = cyc(SKH_NS);
  localparam int unsigned SKL = cyc(SKL_NS);
  localparam int unsigned CSH = cyc(CSH_NS);
  localparam int unsigned EWORD = CSS + 26 * (DIS + SKH + SKL) + CSH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_station = 1'b0;
  logic [3:0]  req_addr = '0;
  logic        req_ready, done, ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic [15:0] rd_word;
  logic [47:0] station_addr;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  always #2 clk = ~clk;

  mw_eeprom_reader #(
    .CLK_MHZ(MHZ), .T_CSS_NS(CSS_NS), .T_DIS_NS(DIS_NS),
    .T_SKH_NS(SKH_NS), .T_SKL_NS(SKL_NS), .T_CSH_NS(CSH_NS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_station(req_station), .req_addr(req_addr), .done(done),
    .rd_word(rd_word), .station_addr(station_addr),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_station(input logic [15:0] w0, w1, w2);
    return {w0, w1, w2};
  endfunction

  // ---------------- behavioural EEPROM model ----------------
  logic [15:0] mem [16];
  logic        p_cs = 1'b0, p_sk = 1'b0, p_di = 1'b0;
  int unsigned c_cs = 1000, c_sk = 1000, c_di = 1000;
  int unsigned bitcnt = 0;
  logic [9:0]  cmd = '0;
  logic [3:0]  m_addr = '0;
  logic [3:0]  a_hist [3];

  always @(negedge clk) begin
    if (!rst_n) begin
      p_cs = 1'b0; p_sk = 1'b0; p_di = 1'b0;
      c_cs = 1000; c_sk = 1000; c_di = 1000; bitcnt = 0; ee_do = 1'b0;
    end else begin
      if (ee_cs && !p_cs) begin
        // R6 gap before a new frame
        chk(c_cs >= CSH, "R6 cs low gap", 64'(c_cs), 64'(CSH));
        bitcnt = 0;
      end
      if (!ee_cs && p_cs) begin
        // R5 pulse count per frame
        chk(bitcnt == 26, "R5 clock pulses per frame", 64'(bitcnt), 64'd26);
        ee_do = 1'b0;
      end
      if (ee_sk && !p_sk) begin
        chk(ee_cs, "R3 sk while cs high", 64'(ee_cs), 64'd1);
        chk(c_di >= DIS, "R3 data setup", 64'(c_di), 64'(DIS));
        if (bitcnt == 0) chk(c_cs >= CSS + DIS, "R3 cs setup", 64'(c_cs), 64'(CSS + DIS));
        else chk(c_sk >= SKL, "R4 sk low time", 64'(c_sk), 64'(SKL));
        if (bitcnt < 10) begin
          cmd = {cmd[8:0], ee_di};
          if (bitcnt == 9) begin
            chk(cmd[9:4] == 6'b011000, "R2 frame pattern", 64'(cmd), 64'(10'h180 | cmd[3:0]));
            m_addr = cmd[3:0];
            a_hist[0] = a_hist[1]; a_hist[1] = a_hist[2]; a_hist[2] = m_addr;
          end
        end else begin
          chk(ee_di == 1'b0, "R2 di low in data phase", 64'(ee_di), 64'd0);
          ee_do = mem[m_addr][15 - (bitcnt - 10)];
        end
        bitcnt++;
      end
      if (!ee_sk && p_sk) chk(c_sk >= SKH, "R4 sk high time", 64'(c_sk), 64'(SKH));
      c_cs = (ee_cs != p_cs) ? 1 : c_cs + 1;
      c_sk = (ee_sk != p_sk) ? 1 : c_sk + 1;
      c_di = (ee_di != p_di) ? 1 : c_di + 1;
      p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
    end
  end

  // ---------------- stimulus ----------------
  logic [47:0] last_station = '0;

  task automatic run_op(input bit station, input logic [3:0] addr, input bit inject);
    int unsigned lat;
    int unsigned exp_lat;
    logic [15:0] prev_word;
    logic [15:0] exp_word;
    prev_word = rd_word;
    exp_lat = station ? 3 * (EWORD + 1) : EWORD + 1;
    exp_word = station ? mem[2] : mem[addr];
    @(negedge clk);
    chk(req_ready, "R8 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_station = station; req_addr = addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 4000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (inject && lat == 30) begin
        chk(!req_ready, "R8 ready low while busy", 64'(req_ready), 64'd0);
        chk(rd_word == prev_word, "R9 rd_word held mid-read", 64'(rd_word), 64'(prev_word));
        req_valid = 1'b1; req_station = ~station; req_addr = ~addr;
      end
      if (inject && lat == 33) req_valid = 1'b0;
    end
    chk(lat == exp_lat, "R10 done latency", 64'(lat), 64'(exp_lat));
    if (station) begin
      chk(station_addr == exp_station(mem[0], mem[1], mem[2]), "R7 packed station address",
          64'(station_addr), 64'(exp_station(mem[0], mem[1], mem[2])));
      chk({a_hist[0], a_hist[1], a_hist[2]} == 12'h012, "R7 word order 0,1,2",
          64'({a_hist[0], a_hist[1], a_hist[2]}), 64'h012);
      chk(rd_word == exp_word, "R7 rd_word holds word2", 64'(rd_word), 64'(exp_word));
      last_station = station_addr;
    end else begin
      chk(m_addr == addr, "R2 address in frame", 64'(m_addr), 64'(addr));
      chk(rd_word == exp_word, "R5 single word data", 64'(rd_word), 64'(exp_word));
      chk(station_addr == last_station, "R9 station_addr unchanged", 64'(station_addr), 64'(last_station));
    end
    @(negedge clk);
    chk(!done, "R9 done one cycle", 64'(done), 64'd0);
    chk(req_ready, "R8 ready after done", 64'(req_ready), 64'd1);
    if (inject) begin
      repeat (6) @(negedge clk);
      chk(!ee_cs && !done, "R8 ignored request started nothing", 64'({ee_cs, done}), 64'd0);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 16; i++) mem[i] = 16'($urandom);
    mem[0] = 16'h0000; mem[1] = 16'hA55A; mem[2] = 16'h8001; mem[15] = 16'hFFFF;
    for (int i = 0; i < 3; i++) a_hist[i] = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    chk({ee_cs, ee_sk, ee_di, done} == 4'b0, "R1 pins low in reset", 64'({ee_cs, ee_sk, ee_di, done}), 64'd0);
    chk(req_ready, "R1 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, done} == 4'b0, "R1 pins low after reset", 64'({ee_cs, ee_sk, ee_di, done}), 64'd0);
    chk(rd_word == 16'h0, "R1 rd_word zero", 64'(rd_word), 64'd0);
    chk(station_addr == 48'h0, "R1 station_addr zero", 64'(station_addr), 64'd0);

    // directed corner cases
    run_op(1'b0, 4'd0, 1'b0);
    run_op(1'b0, 4'd15, 1'b0);
    run_op(1'b1, 4'd9, 1'b0);
    run_op(1'b0, 4'd5, 1'b1);
    run_op(1'b1, 4'd3, 1'b1);
    mem[0] = 16'hFFFF; mem[1] = 16'h0000; mem[2] = 16'h5AA5;
    run_op(1'b1, 4'd0, 1'b0);
    run_op(1'b0, 4'd2, 1'b0);

    // constrained random
    for (int k = 0; k < 24; k++) begin
      bit st;
      if (($urandom % 3) == 0) mem[$urandom % 16] = 16'($urandom);
      st = (($urandom % 4) == 0);
      run_op(st, 4'($urandom), (($urandom % 5) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule